// File: doc/BRIEF.md
# GPIO Port Register Bank with Masked-Write Alias

This block is the register bank for one group of four general-purpose I/O ports, eight pins each. Software reaches it over a plain 32-bit register bus: one address, a write enable, write data, and a read-data path that is combinational on the address. Each port has eight register slots:

- pin enable
- drive enable
- output value
- sampled input
- interrupt status
- interrupt enable
- interrupt type
- a write-only status-clear slot

The block drives the pad outputs and pad drive enables. It samples the pad inputs once per clock. It also exports the interrupt configuration and per-pin status-clear strobes to a separate interrupt-sense block, which in turn raises status bits through a set input.

A second address window mirrors the writable slots, apart from the input and clear slots. Writes to that window carry a per-bit mask in byte 1 and new bit values in byte 0. Software can therefore change a single pin's setting in one bus write, with no read-modify-write sequence and no lock.

The bank's plain window starts at `BANK_IDX * BANK_STRIDE`, and the masked window sits `MASK_OFFSET` above it. Inside each window the register address is:

- byte offset 0x00 + function × 0x10 + port × 4
- function codes: 0 pin enable, 1 drive enable, 2 output, 3 input, 4 status, 5 interrupt enable, 6 interrupt type, 7 clear

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every register reads zero, and `pad_oe`, `pad_out`, `int_status`, `int_en`, `int_type` and `sense_clr` are all zero.
- R2: A write in the plain window at base + function×0x10 + port×4 stores the value, and a read at the same address returns it. The 8-bit registers keep write-data bits 7:0 and read zero in bits 31:8. The interrupt-type register keeps bits 23:0 and reads zero in bits 31:24.
- R3: A write in the masked window (plain address + `MASK_OFFSET`) changes bit n of the target register to write-data bit n only where write-data bit 8+n is 1, and leaves every other bit unchanged. For the interrupt-type register only bits 7:0 are reachable this way, and bits 23:8 keep their value.
- R4: A read in the masked window returns the plain register value in bits 7:0 and zero in bits 31:8. The masked input (function 3) and clear (function 7) slots read zero, and writes to them are ignored.
- R5: The input register returns `pad_in` as sampled at the previous clock edge. Writes to it are ignored.
- R6: A write to the clear slot with data bit n = 1 clears status bit n, and with bit n = 0 leaves it alone. The written bits appear on `sense_clr` during the write cycle. The slot reads zero.
- R7: A 1 on `sense_set` sets the matching status bit at the next edge, and wins over a clear in the same cycle. Status may also be written through the plain and masked windows.
- R8: For each pin, `pad_oe` is 1 exactly when both its pin-enable bit and its drive-enable bit are 1. `pad_out` follows the output register.
- R9: `int_en` mirrors the interrupt-enable registers, 8 bits per port. `int_type` mirrors the interrupt-type registers, 24 bits per port with port p at bits 24p+23:24p.
- R10: Addresses outside both windows read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | PORTS*PINS | Pad input levels |
| pad_out | output | PORTS*PINS | Pad output values |
| pad_oe | output | PORTS*PINS | Pad drive enables |
| sense_set | input | PORTS*PINS | Status set requests from interrupt sense |
| sense_clr | output | PORTS*PINS | Status clear strobes to interrupt sense |
| int_status | output | PORTS*PINS | Interrupt status bits |
| int_en | output | PORTS*PINS | Interrupt enable bits |
| int_type | output | 3*PORTS*PINS | Interrupt type fields |

## Verification
A wrong register bit is visible in two places:

- at once, on the pad or interrupt-configuration outputs;
- on the next read of that slot.

A mask applied in reverse, or a write that lands on the wrong port, corrupts a register that is read back later. The bench therefore reads every neighbour it touched, not only the target. Status faults appear within one cycle: a lost set, a clear that does not honour its zero bits, or a clear that beats a simultaneous set. Decode faults appear as non-zero data from slots that should read zero, or as a stored value that changes after a write outside both windows.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [2:0] {
      FN_CNF = 3'd0,
      FN_OE  = 3'd1,
      FN_OUT = 3'd2,
      FN_IN  = 3'd3,
      FN_STA = 3'd4,
      FN_ENB = 3'd5,
      FN_LVL = 3'd6,
      FN_CLR = 3'd7
   } gpio_fn_e;

   localparam int unsigned WIN_BYTES = 128;

endpackage

// File: rtl/gpio_win_decode.sv
module gpio_win_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned PLAIN_BASE  = 256,
   parameter int unsigned MASK_OFFSET = 128,
   parameter int unsigned PORTS       = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_plain,
   output logic              hit_mask,
   output gpio_fn_e          fn,
   output logic [1:0]        port
);

   localparam int unsigned MASK_BASE = PLAIN_BASE + MASK_OFFSET;
   localparam logic [ADDR_W:0] P_LO = (ADDR_W+1)'(PLAIN_BASE);
   localparam logic [ADDR_W:0] P_HI = (ADDR_W+1)'(PLAIN_BASE + WIN_BYTES);
   localparam logic [ADDR_W:0] M_LO = (ADDR_W+1)'(MASK_BASE);
   localparam logic [ADDR_W:0] M_HI = (ADDR_W+1)'(MASK_BASE + WIN_BYTES);

   logic [ADDR_W:0] a_ext;
   logic            in_p;
   logic            in_m;
   logic [ADDR_W:0] off;
   logic            port_ok;
   logic            unused_low;

   assign a_ext = {1'b0, addr};
   assign in_p  = (a_ext >= P_LO) && (a_ext < P_HI);
   assign in_m  = (a_ext >= M_LO) && (a_ext < M_HI);
   assign off   = in_m ? (a_ext - M_LO) : (a_ext - P_LO);

   assign fn      = gpio_fn_e'(off[6:4]);
   assign port    = off[3:2];
   assign port_ok = (32'(port) < PORTS);

   assign hit_plain = in_p && port_ok;
   assign hit_mask  = in_m && port_ok;

   assign unused_low = ^{off[ADDR_W:7], off[1:0]};

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_wr,
   input  logic                masked,
   input  gpio_fn_e            fn,
   input  logic [31:0]         wdata,
   input  logic [PINS-1:0]     pad_in,
   input  logic [PINS-1:0]     set_in,
   output logic [PINS-1:0]     cnf,
   output logic [PINS-1:0]     oe,
   output logic [PINS-1:0]     out,
   output logic [PINS-1:0]     in_q,
   output logic [PINS-1:0]     sta,
   output logic [PINS-1:0]     enb,
   output logic [3*PINS-1:0]   lvl,
   output logic [PINS-1:0]     clr_bits
);

   localparam int unsigned LVL_W = 3 * PINS;

   logic [PINS-1:0]  d;
   logic [PINS-1:0]  m;
   logic             wp;
   logic             wm;
   logic [PINS-1:0]  cnf_n, oe_n, out_n, enb_n, sta_sw, sta_n;
   logic [LVL_W-1:0] lvl_n;
   logic             unused_hi;

   assign d  = wdata[PINS-1:0];
   assign m  = wdata[8 +: PINS];
   assign wp = sel_wr && !masked;
   assign wm = sel_wr && masked;
   assign unused_hi = ^wdata[31:LVL_W];

   function automatic logic [PINS-1:0] upd(
      input logic [PINS-1:0] old,
      input logic            hp,
      input logic            hm,
      input logic [PINS-1:0] dv,
      input logic [PINS-1:0] mv
   );
      if (hp)      return dv;
      else if (hm) return (old & ~mv) | (dv & mv);
      else         return old;
   endfunction

   always_comb begin
      cnf_n  = upd(cnf, wp && fn == FN_CNF, wm && fn == FN_CNF, d, m);
      oe_n   = upd(oe,  wp && fn == FN_OE,  wm && fn == FN_OE,  d, m);
      out_n  = upd(out, wp && fn == FN_OUT, wm && fn == FN_OUT, d, m);
      enb_n  = upd(enb, wp && fn == FN_ENB, wm && fn == FN_ENB, d, m);
      sta_sw = upd(sta, wp && fn == FN_STA, wm && fn == FN_STA, d, m);
      if (wp && fn == FN_CLR) sta_sw = sta & ~d;
      sta_n  = sta_sw | set_in;
      lvl_n  = lvl;
      if (wp && fn == FN_LVL)
         lvl_n = wdata[LVL_W-1:0];
      else if (wm && fn == FN_LVL)
         lvl_n = {lvl[LVL_W-1:PINS], (lvl[PINS-1:0] & ~m) | (d & m)};
   end

   assign clr_bits = (wp && fn == FN_CLR) ? d : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnf  <= '0;
         oe   <= '0;
         out  <= '0;
         in_q <= '0;
         sta  <= '0;
         enb  <= '0;
         lvl  <= '0;
      end else begin
         cnf  <= cnf_n;
         oe   <= oe_n;
         out  <= out_n;
         in_q <= pad_in;
         sta  <= sta_n;
         enb  <= enb_n;
         lvl  <= lvl_n;
      end
   end

   // R3: masked write moves only the masked bits
   a_r3_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wm && fn == FN_OE) |=>
         (((oe & ~$past(m)) == ($past(oe) & ~$past(m))) &&
          ((oe & $past(m)) == ($past(d) & $past(m)))));

   // R6: a clear bit removes status unless a set arrives in the same cycle
   a_r6_clear_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && fn == FN_CLR) |=> ((sta & $past(d) & ~$past(set_in)) == '0));

   // R7: a set request is never lost
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_in != '0) |=> ((sta & $past(set_in)) == $past(set_in)));

   // R10: with no write for this port the configuration holds
   a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> ($stable(cnf) && $stable(oe) && $stable(out) &&
                   $stable(enb) && $stable(lvl)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned PORTS       = 4,
   parameter int unsigned PINS        = 8,
   parameter int unsigned BANK_STRIDE = 256,
   parameter int unsigned BANK_IDX    = 1,
   parameter int unsigned MASK_OFFSET = 128
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_we,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   input  logic [PORTS*PINS-1:0]     pad_in,
   output logic [PORTS*PINS-1:0]     pad_out,
   output logic [PORTS*PINS-1:0]     pad_oe,
   input  logic [PORTS*PINS-1:0]     sense_set,
   output logic [PORTS*PINS-1:0]     sense_clr,
   output logic [PORTS*PINS-1:0]     int_status,
   output logic [PORTS*PINS-1:0]     int_en,
   output logic [3*PORTS*PINS-1:0]   int_type
);

   localparam int unsigned LVL_W      = 3 * PINS;
   localparam int unsigned PLAIN_BASE = BANK_IDX * BANK_STRIDE;

   if (PINS < 1 || PINS > 8) begin : g_bad_pins
      $error("PINS must lie in 1..8");
   end
   if (PORTS < 1 || PORTS > 4) begin : g_bad_ports
      $error("PORTS must lie in 1..4");
   end
   if (BANK_STRIDE < WIN_BYTES || (BANK_STRIDE & (BANK_STRIDE - 1)) != 0) begin : g_bad_stride
      $error("BANK_STRIDE must be a power of two of at least 128");
   end
   if (MASK_OFFSET < WIN_BYTES || (MASK_OFFSET % WIN_BYTES) != 0) begin : g_bad_moff
      $error("MASK_OFFSET must be a multiple of 128");
   end
   if (ADDR_W < 8 || ADDR_W > 30 ||
       (PLAIN_BASE + MASK_OFFSET + WIN_BYTES) > (1 << ADDR_W)) begin : g_bad_addr
      $error("both windows must fit in the address space");
   end

   logic     hit_plain;
   logic     hit_mask;
   gpio_fn_e dec_fn;
   logic [1:0] dec_port;

   gpio_win_decode #(
      .ADDR_W      (ADDR_W),
      .PLAIN_BASE  (PLAIN_BASE),
      .MASK_OFFSET (MASK_OFFSET),
      .PORTS       (PORTS)
   ) dec_i (
      .addr      (bus_addr),
      .hit_plain (hit_plain),
      .hit_mask  (hit_mask),
      .fn        (dec_fn),
      .port      (dec_port)
   );

   logic [PINS-1:0]  cnf_a [PORTS];
   logic [PINS-1:0]  oe_a  [PORTS];
   logic [PINS-1:0]  out_a [PORTS];
   logic [PINS-1:0]  in_a  [PORTS];
   logic [PINS-1:0]  sta_a [PORTS];
   logic [PINS-1:0]  enb_a [PORTS];
   logic [LVL_W-1:0] lvl_a [PORTS];

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      logic sel;
      assign sel = bus_we && (hit_plain || hit_mask) && (dec_port == 2'(p));

      gpio_port_regs #(.PINS(PINS)) regs_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_wr   (sel),
         .masked   (hit_mask),
         .fn       (dec_fn),
         .wdata    (bus_wdata),
         .pad_in   (pad_in[p*PINS +: PINS]),
         .set_in   (sense_set[p*PINS +: PINS]),
         .cnf      (cnf_a[p]),
         .oe       (oe_a[p]),
         .out      (out_a[p]),
         .in_q     (in_a[p]),
         .sta      (sta_a[p]),
         .enb      (enb_a[p]),
         .lvl      (lvl_a[p]),
         .clr_bits (sense_clr[p*PINS +: PINS])
      );

      assign pad_out[p*PINS +: PINS]     = out_a[p];
      assign pad_oe[p*PINS +: PINS]      = cnf_a[p] & oe_a[p];
      assign int_status[p*PINS +: PINS]  = sta_a[p];
      assign int_en[p*PINS +: PINS]      = enb_a[p];
      assign int_type[p*LVL_W +: LVL_W]  = lvl_a[p];
   end

   logic [31:0] rd_v;

   always_comb begin
      rd_v = '0;
      for (int p = 0; p < PORTS; p++) begin
         if (dec_port == 2'(p)) begin
            unique case (dec_fn)
               FN_CNF:  rd_v = 32'(cnf_a[p]);
               FN_OE:   rd_v = 32'(oe_a[p]);
               FN_OUT:  rd_v = 32'(out_a[p]);
               FN_IN:   rd_v = 32'(in_a[p]);
               FN_STA:  rd_v = 32'(sta_a[p]);
               FN_ENB:  rd_v = 32'(enb_a[p]);
               FN_LVL:  rd_v = 32'(lvl_a[p]);
               default: rd_v = '0;
            endcase
         end
      end
      if (hit_plain)
         bus_rdata = rd_v;
      else if (hit_mask && dec_fn != FN_IN && dec_fn != FN_CLR)
         bus_rdata = {24'b0, rd_v[7:0]};
      else
         bus_rdata = '0;
   end

   // R4: the masked window never returns bits above byte 0
   a_r4_mask_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hit_mask |-> (bus_rdata[31:8] == 24'b0));

   // R10: decode misses read zero
   a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_plain || hit_mask) |-> (bus_rdata == 32'b0));

   // R6: clear strobes only appear on a bus write
   a_r6_clr_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_clr != '0) |-> (bus_we && hit_plain));

endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb_top;

   localparam int unsigned NP = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [11:0]     bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   pad_in = '0;
   logic [NP-1:0]   pad_out, pad_oe, sense_clr, int_status, int_en;
   logic [NP-1:0]   sense_set = '0;
   logic [3*NP-1:0] int_type;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   gpio_bank_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .sense_set(sense_set),
      .sense_clr(sense_clr), .int_status(int_status), .int_en(int_en),
      .int_type(int_type)
   );

   // address helpers: plain base 0x100, masked base 0x180
   function automatic logic [11:0] pa(input int fn, input int port);
      return 12'(12'h100 + fn * 16 + port * 4);
   endfunction
   function automatic logic [11:0] ma(input int fn, input int port);
      return 12'(12'h180 + fn * 16 + port * 4);
   endfunction

   task automatic chk(input logic [95:0] act, input logic [95:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(96'(bus_rdata), 96'(e), t);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      bus_addr = a; bus_we = 1'b0;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk); #1;
   endtask

   task automatic idle();
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int p = 0; p < 4; p++) rd(pa(0, p), 32'h0, "R1 cnf reset");
      rd(pa(6, 1), 32'h0, "R1 type reset");
      rd(pa(4, 0), 32'h0, "R1 status reset");
      @(negedge clk);
      chk(96'(pad_oe), 96'h0, "R1 pad_oe");
      chk(96'(pad_out), 96'h0, "R1 pad_out");
      chk(96'(int_status), 96'h0, "R1 int_status");
      chk(96'(int_en), 96'h0, "R1 int_en");
      chk(int_type, 96'h0, "R1 int_type");
      @(posedge clk); #1;

      // R2 plain writes
      wr(pa(0, 0), 32'hFFFF_FFA5);
      wr(pa(0, 1), 32'h0000_0011);
      wr(pa(1, 0), 32'h0000_000F);
      wr(pa(2, 0), 32'h0000_003C);
      wr(pa(6, 2), 32'hFFFF_FFFF);
      wr(pa(5, 3), 32'h0000_0081);
      rd(pa(0, 0), 32'h0000_00A5, "R2 cnf p0");
      rd(pa(0, 1), 32'h0000_0011, "R2 cnf p1");
      rd(pa(1, 0), 32'h0000_000F, "R2 oe p0");
      rd(pa(2, 0), 32'h0000_003C, "R2 out p0");
      rd(pa(6, 2), 32'h00FF_FFFF, "R2 type p2");
      rd(pa(5, 3), 32'h0000_0081, "R2 enb p3");
      @(negedge clk);
      chk(96'(pad_oe), 96'h0000_0005, "R8 pad_oe");
      chk(96'(pad_out), 96'h0000_003C, "R8 pad_out");
      chk(96'(int_en), 96'h8100_0000, "R9 int_en");
      chk(int_type, {24'h0, 24'hFF_FFFF, 48'h0}, "R9 int_type");
      @(posedge clk); #1;

      // R3 masked writes
      wr(ma(1, 0), 32'h0000_3070);
      rd(pa(1, 0), 32'h0000_003F, "R3 oe set bits 5:4");
      wr(ma(1, 0), 32'h0000_0100);
      rd(pa(1, 0), 32'h0000_003E, "R3 oe clear bit 0");
      wr(ma(0, 0), 32'h0000_0F00);
      rd(pa(0, 0), 32'h0000_00A0, "R3 cnf low nibble");
      rd(pa(0, 1), 32'h0000_0011, "R3 neighbour port untouched");
      wr(ma(6, 2), 32'h0000_FF00);
      rd(pa(6, 2), 32'h00FF_FF00, "R3 type upper kept");

      // R4 masked reads
      rd(ma(1, 0), 32'h0000_003E, "R4 masked oe read");
      rd(ma(6, 2), 32'h0000_0000, "R4 masked type byte0");
      rd(ma(3, 0), 32'h0000_0000, "R4 masked input slot");
      rd(ma(7, 0), 32'h0000_0000, "R4 masked clear slot");
      @(negedge clk);
      chk(96'(pad_oe), 96'h0000_0020, "R8 pad_oe after mask");
      @(posedge clk); #1;

      // R5 input sampling
      pad_in = 32'hDEAD_BEEF;
      idle();
      rd(pa(3, 0), 32'h0000_00EF, "R5 in p0");
      rd(pa(3, 3), 32'h0000_00DE, "R5 in p3");
      wr(pa(3, 0), 32'h0000_0000);
      wr(ma(3, 0), 32'h0000_FFFF);
      rd(pa(3, 0), 32'h0000_00EF, "R5 in write ignored");

      // R7 status set from sense logic
      sense_set = 32'h0000_5A00;
      idle();
      sense_set = '0;
      rd(pa(4, 1), 32'h0000_005A, "R7 status set");
      @(negedge clk);
      chk(96'(int_status), 96'h0000_5A00, "R7 int_status");
      @(posedge clk); #1;

      // R6 clear
      bus_addr = pa(7, 1); bus_we = 1'b1; bus_wdata = 32'h0000_0012;
      @(negedge clk);
      chk(96'(sense_clr), 96'h0000_1200, "R6 clear strobe");
      @(posedge clk); #1;
      bus_we = 1'b0; bus_wdata = '0;
      rd(pa(4, 1), 32'h0000_0048, "R6 clear ones");
      wr(pa(7, 1), 32'h0000_0000);
      rd(pa(4, 1), 32'h0000_0048, "R6 clear zeros no effect");
      rd(pa(7, 1), 32'h0000_0000, "R6 clear reads zero");
      @(negedge clk);
      chk(96'(sense_clr), 96'h0, "R6 no strobe on read");
      @(posedge clk); #1;

      // R7 set wins, software writes
      sense_set = 32'h0000_4000;
      wr(pa(7, 1), 32'h0000_0040);
      sense_set = '0;
      rd(pa(4, 1), 32'h0000_0048, "R7 set beats clear");
      wr(pa(4, 1), 32'h0000_0001);
      rd(pa(4, 1), 32'h0000_0001, "R7 plain status write");
      wr(ma(4, 1), 32'h0000_8080);
      rd(pa(4, 1), 32'h0000_0081, "R7 masked status write");

      // R10 outside windows
      wr(12'h000, 32'h0000_00FF);
      wr(12'h200, 32'h0000_00FF);
      wr(12'h0FC, 32'h0000_00FF);
      rd(12'h000, 32'h0, "R10 low miss read");
      rd(12'h200, 32'h0, "R10 high miss read");
      rd(pa(0, 0), 32'h0000_00A0, "R10 cnf unchanged");
      rd(pa(0, 3), 32'h0000_0000, "R10 cnf p3 unchanged");

      idle();
      idle();
      finish_run();
   end

endmodule